// File: doc/BRIEF.md
# CPU Clock Stall Arbiter

This block sits between the display fetch logic and the processor. It divides the fast 16 MHz clock into 500 ns memory slots. At the end of every slot it decides who owns the next one: the video fetch engine or the CPU. From the same decision it sets the CPU clock enable for the whole next slot. The CPU clock therefore advances at the full 2 MHz slot rate, at 1 MHz, or not at all.

The decision depends on three things: the bandwidth class of the screen mode, whether the raster is in the active pixel region, and the CPU's top address line.

- Accesses to the upper half of the address space never touch the shared RAM. They keep full rate at all times.
- Only lower-half accesses are held, and only when they fall on a slot that video owns.

The memory sequencer uses the slot owner flag to drive the RAM strobes and the address multiplexer.

Top module: `cpu_clock_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first slot after it rises, `cpu_ce` is 1 and `cpu_slot` is 1 (1 = CPU owns the slot, 0 = video owns it).
- R2: A slot lasts `PHASES` (default 8) clock cycles. `slot_start` is 1 in the first cycle of each slot and 0 in the others. The first cycle after reset is the first cycle of a slot.
- R3: `cpu_ce` and `cpu_slot` change only at a slot boundary. They are computed from the inputs as sampled in the last cycle of the previous slot. Input changes at any other time have no effect.
- R4: If `disp_active` is 0 when sampled, the next slot goes to the CPU with `cpu_ce` = 1.
- R5: With `wide_mode` = 0 (40 bytes per line) and `disp_active` = 1, slots are numbered from 0. Slot 0 is the first slot decided with `disp_active` high after a slot decided with it low. Even-numbered slots belong to video and odd-numbered slots belong to the CPU.
- R6: With `wide_mode` = 1 (80 bytes per line) and `disp_active` = 1, every slot belongs to video.
- R7: If `cpu_a15` is 1 when sampled, `cpu_ce` is 1 for the next slot, whoever owns that slot.
- R8: `cpu_ce` is 0 only for a slot that video owns and that was decided with `cpu_a15` = 0. The CPU therefore stalls for as long as it addresses lower memory during video-owned slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 = 80-byte-per-line mode, 0 = 40-byte-per-line mode |
| disp_active | input | 1 | Raster is inside the pixel fetch region |
| cpu_a15 | input | 1 | Top CPU address line |
| cpu_ce | output | 1 | CPU clock enable, held for the whole slot |
| cpu_slot | output | 1 | Slot owner: 1 = CPU, 0 = video fetch |
| slot_start | output | 1 | High in the first cycle of each slot |

## Verification
The directed runs cover five cases, each showing one part of the decision:
- Idle display isolates the default full-rate grant.
- A 40-byte active run with lower-memory addresses shows the even/odd alternation and the restart of the slot count when the display goes active again.
- The same run with upper addresses separates ownership from stalling.
- An 80-byte active run shows the complete stall.
- A return to idle shows the release.

Random slots then mix all three inputs and glitch them in the middle of each slot. This shows that only the value in the last cycle of a slot counts, and that the outputs never change inside a slot.

// File: rtl/cpu_clock_arbiter.sv
module cpu_clock_arbiter #(
  parameter int PHASES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wide_mode,
  input  logic disp_active,
  input  logic cpu_a15,
  output logic cpu_ce,
  output logic cpu_slot,
  output logic slot_start
);
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] phase;
  logic          idx_odd;
  logic          at_end;
  logic          video_next;

  assign at_end     = (phase == LAST);
  assign video_next = disp_active && (wide_mode || !idx_odd);
  assign slot_start = (phase == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= '0;
      idx_odd  <= 1'b0;
      cpu_ce   <= 1'b1;
      cpu_slot <= 1'b1;
    end else begin
      phase <= at_end ? '0 : phase + 1'b1;
      if (at_end) begin
        idx_odd  <= disp_active ? ~idx_odd : 1'b0;
        cpu_slot <= !video_next;
        cpu_ce   <= cpu_a15 || !video_next;
      end
    end
  end

  // R7
  a15_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && cpu_a15) |=> cpu_ce);

  // R4
  idle_cpu_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !disp_active) |=> (cpu_slot && cpu_ce));

  // R6
  wide_all_video_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && disp_active && wide_mode) |=> !cpu_slot);

  // R3
  hold_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_end |=> ($stable(cpu_ce) && $stable(cpu_slot)));

  // R8
  stall_only_video_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ce |-> !cpu_slot);

  // R2
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !slot_start || (PHASES == 1));
endmodule

// File: tb/sim_cpu_clock_arbiter.sv
module sim_cpu_clock_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b0, disp_active = 1'b0, cpu_a15 = 1'b0;
  logic cpu_ce, cpu_slot, slot_start;
  int checks = 0, fails = 0;
  bit done = 0;
  logic exp_ce = 1'b1, exp_slot = 1'b1;
  bit model_odd = 0;

  always #4 clk = ~clk;

  cpu_clock_arbiter #(.PHASES(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .disp_active(disp_active),
    .cpu_a15(cpu_a15), .cpu_ce(cpu_ce), .cpu_slot(cpu_slot), .slot_start(slot_start)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic is_video(input logic w, input logic a, input bit odd);
    return a && (w || !odd);
  endfunction

  task automatic run_slot(input logic w, input logic a, input logic h, input bit glitch);
    logic v;
    if (glitch) begin
      wide_mode = $urandom; disp_active = $urandom; cpu_a15 = $urandom;
    end else begin
      wide_mode = w; disp_active = a; cpu_a15 = h;
    end
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      if (k == 3) begin wide_mode = w; disp_active = a; cpu_a15 = h; end
      chk("R3", cpu_ce, exp_ce, "cpu_ce mid-slot");
      chk("R3", cpu_slot, exp_slot, "cpu_slot mid-slot");
      chk("R2", slot_start, 1'b0, "slot_start mid-slot");
    end
    @(negedge clk);
    v = is_video(w, a, model_odd);
    model_odd = a ? !model_odd : 1'b0;
    exp_slot = !v;
    exp_ce = h || !v;
    chk("R2", slot_start, 1'b1, "slot_start at boundary");
    if (!a)           chk("R4", cpu_slot, 1'b1, "idle owner");
    else if (w)       chk("R6", cpu_slot, 1'b0, "wide owner");
    else              chk("R5", cpu_slot, exp_slot, "narrow owner");
    if (h)            chk("R7", cpu_ce, 1'b1, "a15 high enable");
    else              chk("R8", cpu_ce, exp_ce, "stall rule");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", cpu_ce, 1'b1, "reset cpu_ce");
    chk("R1", cpu_slot, 1'b1, "reset cpu_slot");
    rst_n = 1'b1;
    chk("R2", slot_start, 1'b1, "first slot start");
    // R4 idle
    for (int i = 0; i < 3; i++) run_slot(1'b0, 1'b0, 1'b0, 1'b0);
    // R5 narrow, lower memory: alternation
    for (int i = 0; i < 6; i++) run_slot(1'b0, 1'b1, 1'b0, 1'b0);
    // R5 restart after idle gap
    run_slot(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) run_slot(1'b0, 1'b1, 1'b0, 1'b0);
    // R7 upper memory during video
    for (int i = 0; i < 4; i++) run_slot(1'b0, 1'b1, 1'b1, 1'b0);
    // R6 wide stall then upper memory
    for (int i = 0; i < 4; i++) run_slot(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) run_slot(1'b1, 1'b1, 1'b1, 1'b0);
    run_slot(1'b1, 1'b0, 1'b0, 1'b0);
    // random with mid-slot glitches
    for (int i = 0; i < 400; i++)
      run_slot($urandom, ($urandom % 4) != 0, $urandom, 1'b1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule